// File: doc/BRIEF.md
# Masked Content-Addressable Memory

This block is a small associative store of `2^ADDR_W` words, each `DATA_W` bits wide. A search value is held in a pattern register and a separate care-mask register selects which bit positions take part in a comparison. Bit positions whose mask bit is 0 match unconditionally. When the search strobe is raised, every stored word is compared against the masked pattern at once. The per-word outcome is captured in a match register that holds one flag per word.

Alongside the match register, the block registers an any-hit flag and the index of the lowest matching word. A write port stores a word at an explicit index and sets or clears that word's valid flag. A word whose valid flag is clear never reports a match. The block suits lookups such as tag search or classification, where software or another engine loads entries and then issues masked queries.

Top module: `masked_cam`

## Requirements
- R1: While `rst` is high at a clock edge, the match vector, any-hit flag and hit index clear to 0, every word's valid flag clears, and the pattern and mask registers clear to 0.
- R2: `pat_load` captures `pat_in` into the pattern register and `mask_load` captures `mask_in` into the mask register at the clock edge. A search issued in the same cycle as a load uses the register contents from before that edge.
- R3: A word's match bit is 1 exactly when the word is valid and every bit position with mask bit 1 holds the same value as the pattern. A mask bit of 1 means the position is compared.
- R4: The whole match vector is updated from one comparison of all words, at the clock edge where `search` is high, and is visible one cycle after the strobe.
- R5: While `search` is low, the match vector, any-hit flag and hit index keep their values, even when the pattern, mask or stored words change.
- R6: With `wr_en` high, `wr_data` is stored at index `wr_idx` and that word's valid flag takes the value of `wr_valid`. `wr_valid = 0` removes the word from all later matches.
- R7: A word never written since reset, or written with `wr_valid = 0`, does not match even when the mask is all zeros.
- R8: `hit_any` is 1 exactly when the match vector is non-zero. `hit_idx` is the lowest index whose match bit is 1, and is 0 when no bit is set.
- R9: When a write and a search fall in the same cycle, the search sees the stored word and valid flag as they were before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pat_load | input | 1 | Load the pattern register |
| pat_in | input | DATA_W | New pattern value |
| mask_load | input | 1 | Load the care-mask register |
| mask_in | input | DATA_W | New mask value; 1 = compare this bit |
| search | input | 1 | Search strobe |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | ADDR_W | Word index to write |
| wr_data | input | DATA_W | Word to store |
| wr_valid | input | 1 | Valid flag stored with the word |
| match_vec | output | 2^ADDR_W | Match register, one bit per word |
| hit_any | output | 1 | Any word matched in the last search |
| hit_idx | output | ADDR_W | Lowest matching index |

## Verification
The bench goes after masked comparisons where only the compared bits agree, so a design that ignored the mask or inverted its polarity would report the wrong words. It searches with an all-zero mask after reset and after an invalidating write; a design that let invalid or never-written words match would report stray bits. It places a write and a search to the same word in one cycle, which catches a design that forwards the new data, and it loads a pattern in the same cycle as a search, which catches a design that uses the new value. It also holds the strobe low while changing inputs to catch a match register that is not held, and it checks multi-hit vectors to catch a priority encoder that picks the highest index instead of the lowest.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int unsigned CAM_ADDR_W_DEF = 3;
  localparam int unsigned CAM_DATA_W_DEF = 8;
endpackage

// File: rtl/cam_row.sv
module cam_row #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wvalid,
  input  logic [DATA_W-1:0] pat,
  input  logic [DATA_W-1:0] mask,
  output logic              hit,
  output logic              valid_o
);
  logic [DATA_W-1:0] word_q;
  logic              valid_q;

  // data storage carries no reset; only the valid flag does
  always_ff @(posedge clk) begin
    if (we) word_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     valid_q <= 1'b0;
    else if (we) valid_q <= wvalid;
  end

  assign hit     = valid_q && (((word_q ^ pat) & mask) == '0);
  assign valid_o = valid_q;
endmodule

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned WORDS = 1 << ADDR_W
) (
  input  logic [WORDS-1:0]  req,
  output logic [ADDR_W-1:0] idx
);
  // scan from the top down so the lowest set bit is assigned last
  always_comb begin
    idx = '0;
    for (int i = WORDS - 1; i >= 0; i--) begin
      if (req[i]) idx = ADDR_W'(i);
    end
  end
endmodule

// File: rtl/masked_cam.sv
module masked_cam
  import cam_pkg::*;
#(
  parameter int unsigned ADDR_W = CAM_ADDR_W_DEF,
  parameter int unsigned DATA_W = CAM_DATA_W_DEF,
  localparam int unsigned WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pat_load,
  input  logic [DATA_W-1:0] pat_in,
  input  logic              mask_load,
  input  logic [DATA_W-1:0] mask_in,
  input  logic              search,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_valid,
  output logic [WORDS-1:0]  match_vec,
  output logic              hit_any,
  output logic [ADDR_W-1:0] hit_idx
);
  logic [DATA_W-1:0] pat_q;
  logic [DATA_W-1:0] mask_q;
  logic [WORDS-1:0]  hit_now;
  logic [WORDS-1:0]  valid_vec;
  logic [ADDR_W-1:0] low_idx;
  logic [WORDS-1:0]  match_q;
  logic              any_q;
  logic [ADDR_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pat_q  <= '0;
      mask_q <= '0;
    end else begin
      if (pat_load)  pat_q  <= pat_in;
      if (mask_load) mask_q <= mask_in;
    end
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_row
    cam_row #(.DATA_W(DATA_W)) u_row (
      .clk    (clk),
      .rst    (rst),
      .we     (wr_en && (wr_idx == ADDR_W'(g))),
      .wdata  (wr_data),
      .wvalid (wr_valid),
      .pat    (pat_q),
      .mask   (mask_q),
      .hit    (hit_now[g]),
      .valid_o(valid_vec[g])
    );
  end

  cam_prio_enc #(.ADDR_W(ADDR_W)) u_enc (
    .req(hit_now),
    .idx(low_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      any_q   <= 1'b0;
      idx_q   <= '0;
    end else if (search) begin
      match_q <= hit_now;
      any_q   <= |hit_now;
      idx_q   <= low_idx;
    end
  end

  assign match_vec = match_q;
  assign hit_any   = any_q;
  assign hit_idx   = idx_q;
endmodule

// File: rtl/cam_checker.sv
module cam_checker #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned WORDS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              search,
  input logic [WORDS-1:0]  match_vec,
  input logic              hit_any,
  input logic [ADDR_W-1:0] hit_idx,
  input logic [WORDS-1:0]  valid_vec
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (match_vec == '0 && !hit_any && hit_idx == '0 && valid_vec == '0));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (rst)
    !search |=> ($stable(match_vec) && $stable(hit_any) && $stable(hit_idx)));

  assert_invalid_silent_R7: assert property (@(posedge clk) disable iff (rst)
    search |=> ((match_vec & ~$past(valid_vec)) == '0));

  assert_any_flag_R8: assert property (@(posedge clk) disable iff (rst)
    hit_any == (match_vec != '0));

  assert_idx_set_R8: assert property (@(posedge clk) disable iff (rst)
    hit_any |-> match_vec[hit_idx]);

  assert_idx_lowest_R8: assert property (@(posedge clk) disable iff (rst)
    (match_vec & ((WORDS'(1) << hit_idx) - WORDS'(1))) == '0);

  assert_idx_zero_R8: assert property (@(posedge clk) disable iff (rst)
    !hit_any |-> hit_idx == '0);
endmodule

bind masked_cam cam_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .search   (search),
  .match_vec(match_vec),
  .hit_any  (hit_any),
  .hit_idx  (hit_idx),
  .valid_vec(valid_vec)
);

// File: tb/sim_masked_cam.sv
module sim_masked_cam;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int NW = 1 << AW;
  localparam int NVEC = 7;
  // each entry: {pattern, mask, expected match vector, expected index}
  localparam logic [26:0] VEC [NVEC] = '{
    {8'hA5, 8'hFF, 8'h21, 3'd0},
    {8'hA5, 8'hF0, 8'h25, 3'd0},
    {8'h00, 8'h00, 8'h77, 3'd0},
    {8'hFF, 8'hFF, 8'h00, 3'd0},
    {8'h5A, 8'hFF, 8'h10, 3'd4},
    {8'h00, 8'h0F, 8'h44, 3'd2},
    {8'h3C, 8'h3C, 8'h02, 3'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pat_load = 1'b0, mask_load = 1'b0, search = 1'b0, wr_en = 1'b0, wr_valid = 1'b0;
  logic [DW-1:0] pat_in = '0, mask_in = '0, wr_data = '0;
  logic [AW-1:0] wr_idx = '0;
  logic [NW-1:0] match_vec;
  logic hit_any;
  logic [AW-1:0] hit_idx;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  masked_cam #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .pat_load(pat_load), .pat_in(pat_in),
    .mask_load(mask_load), .mask_in(mask_in), .search(search),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_valid(wr_valid),
    .match_vec(match_vec), .hit_any(hit_any), .hit_idx(hit_idx)
  );

  task automatic check(input string req, input logic [NW-1:0] ev, input logic [AW-1:0] ei);
    logic ea;
    ea = (ev != '0);
    checks++;
    if (match_vec !== ev || hit_any !== ea || hit_idx !== ei) begin
      errors++;
      $display("FAIL %s: got vec=%h any=%b idx=%0d, expected vec=%h any=%b idx=%0d",
               req, match_vec, hit_any, hit_idx, ev, ea, ei);
    end
  endtask

  task automatic write_word(input logic [AW-1:0] i, input logic [DW-1:0] d, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = i; wr_data = d; wr_valid = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_both(input logic [DW-1:0] p, input logic [DW-1:0] m);
    @(negedge clk);
    pat_load = 1'b1; pat_in = p; mask_load = 1'b1; mask_in = m;
    @(negedge clk);
    pat_load = 1'b0; mask_load = 1'b0;
  endtask

  task automatic strobe;
    @(negedge clk);
    search = 1'b1;
    @(negedge clk);
    search = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 8'h00, 3'd0);
    rst = 1'b0;
    // R7: nothing written since reset, mask all zeros, no word may match
    load_both(8'h00, 8'h00);
    strobe();
    check("R7 empty store", 8'h00, 3'd0);

    // R6: fill the store; word 3 written invalid, word 7 untouched
    write_word(3'd0, 8'hA5, 1'b1);
    write_word(3'd1, 8'h3C, 1'b1);
    write_word(3'd2, 8'hA0, 1'b1);
    write_word(3'd3, 8'hFF, 1'b0);
    write_word(3'd4, 8'h5A, 1'b1);
    write_word(3'd5, 8'hA5, 1'b1);
    write_word(3'd6, 8'h00, 1'b1);

    // R3 R4 R8: masked searches from the table
    for (int k = 0; k < NVEC; k++) begin
      load_both(VEC[k][26:19], VEC[k][18:11]);
      strobe();
      check("R3 table search", VEC[k][10:3], VEC[k][2:0]);
    end

    // R5: change pattern and a word with search low; result must hold
    load_both(8'hA5, 8'hFF);
    write_word(3'd1, 8'hA5, 1'b1);
    repeat (2) @(negedge clk);
    check("R5 hold while idle", 8'h02, 3'd1);

    // R2: pattern load in the same cycle as search uses old pattern (A5)
    @(negedge clk);
    pat_load = 1'b1; pat_in = 8'h5A; search = 1'b1;
    @(negedge clk);
    pat_load = 1'b0; search = 1'b0;
    check("R2 search uses old pattern", 8'h23, 3'd0);
    strobe();
    check("R2 new pattern applied", 8'h10, 3'd4);

    // R9: write word 4 and search in the same cycle; search sees old 5A
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd4; wr_data = 8'h00; wr_valid = 1'b1; search = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; search = 1'b0;
    check("R9 old contents on collision", 8'h10, 3'd4);
    strobe();
    check("R9 new contents afterwards", 8'h00, 3'd0);

    // R6 R7: invalidate word 0, mask zero: all valid words except 0 and 3, 7
    write_word(3'd0, 8'hA5, 1'b0);
    load_both(8'h00, 8'h00);
    strobe();
    check("R6 invalidated word silent", 8'h76, 3'd1);

    // R1: reset mid-run clears results and all valid flags
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset clears match", 8'h00, 3'd0);
    strobe();
    check("R1 reset clears valid", 8'h00, 3'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule